// File: doc/BRIEF.md
# Multi-word load transfer splitter

This block sits between a core unit that loads or stores runs of 32-bit words and a bus port that is either 32 or 64 bits wide. It takes one request: a word-aligned start address, a count of 1 to 16 words and a flag that marks the target region as one that only accepts single 32-bit accesses. It turns that request into an ordered series of bus transactions. Each transaction carries an address, a beat width and a beat count.

On a 64-bit port, words that share an aligned doubleword are merged into 64-bit beats. All such beats go out as one burst with a single address phase. A start on an odd word costs one leading 32-bit transfer, and an odd word left at the end costs one trailing 32-bit transfer. A narrow port, or a request with the single-access flag set, always gets one 32-bit transfer per word. The splitter moves to the next transaction only when the bus accepts the current one. It pulses a completion flag once the last transaction has been accepted.

Top module: `xfer_split`

## Requirements
- R1: After reset, `bus_valid` and `done` are low and `req_ready` is high.
- R2: With `BUS_BITS`=32, a request of N words produces N transactions, each with `bus_wide`=0 and `bus_len`=1, at addresses start, start+4, start+8, and so on.
- R3: With `BUS_BITS`=64, the flag clear, N of at least 2 and a start with address bit 2 equal to 0, the first transaction is at the start address with `bus_wide`=1 and `bus_len`=floor(N/2). It is followed, only when N is odd, by one 32-bit transaction at start+8*floor(N/2).
- R4: With `BUS_BITS`=64, the flag clear and address bit 2 of the start equal to 1, the first transaction is a 32-bit one at the start address. The remaining N-1 words then follow the R3 pattern from start+4 (a 64-bit burst when N-1 is at least 2, then a 32-bit tail when N-1 is odd).
- R5: When `req_single` is 1 at request time, every transaction of that request has `bus_wide`=0 and `bus_len`=1, whatever the port width.
- R6: A request of one word produces exactly one transaction, with `bus_wide`=0 and `bus_len`=1, at the start address, on either port width and at either alignment.
- R7: While `bus_valid` is high and `bus_ready` is low, the transaction outputs hold their values into the next cycle.
- R8: `done` is high for exactly one cycle: the cycle right after the edge that accepts the last transaction of a request. In that cycle `bus_valid` is low.
- R9: A request is taken only on an edge where `req_valid` and `req_ready` are both high, and `req_ready` is low while transactions are pending. A `req_valid` raised while busy leaves the transaction series of the running request unchanged and starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Word-aligned start address |
| req_words | input | CNT_W | Word count, 1 to MAX_WORDS |
| req_single | input | 1 | Target region accepts only single 32-bit transfers |
| req_ready | output | 1 | Splitter idle; a request is taken this cycle if valid |
| bus_valid | output | 1 | Transaction presented |
| bus_addr | output | ADDR_W | Transaction start address |
| bus_wide | output | 1 | Beat width: 0 = 32-bit, 1 = 64-bit |
| bus_len | output | CNT_W | Number of beats in the transaction |
| bus_ready | input | 1 | Bus accepts the presented transaction |
| done | output | 1 | One-cycle pulse after the last transaction is accepted |

## Verification
The bench builds two copies side by side on the same stimulus. One has `BUS_BITS`=64 and the other `BUS_BITS`=32, and both keep `MAX_WORDS`=16. Every request therefore shows the merged and the unmerged shape of the same word list at once. The 16-word limit puts the longest 8-beat burst and the 32/64/32 split around it within reach. Back-pressure patterns on `bus_ready` stretch each request over many cycles, so holding under stall and requests raised while busy can both be exercised.

// File: rtl/xfer_split_pkg.sv
package xfer_split_pkg;
  // Beat width of one bus transaction
  typedef enum logic {
    BEAT_W32 = 1'b0,
    BEAT_W64 = 1'b1
  } beat_e;
endpackage

// File: rtl/xfer_plan.sv
// Combinational chunk planner: picks the shape of the next transaction.
module xfer_plan
  import xfer_split_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             wide_ok,   // 64-bit beats allowed for this request
  input  logic             odd_word,  // address bit 2
  input  logic [CNT_W-1:0] rem_words,
  output beat_e            beat,
  output logic [CNT_W-1:0] beats,
  output logic [CNT_W-1:0] used
);
  always_comb begin
    beat  = BEAT_W32;
    beats = CNT_W'(1);
    used  = CNT_W'(1);
    if (wide_ok && !odd_word && rem_words >= CNT_W'(2)) begin
      beat  = BEAT_W64;
      beats = rem_words >> 1;
      used  = (rem_words >> 1) << 1;
    end
  end
endmodule

// File: rtl/xfer_stage.sv
// Registered transaction holding stage facing the bus.
module xfer_stage
  import xfer_split_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              clear,
  input  logic [ADDR_W-1:0] ld_addr,
  input  beat_e             ld_beat,
  input  logic [CNT_W-1:0]  ld_len,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output beat_e             beat,
  output logic [CNT_W-1:0]  len
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      addr  <= '0;
      beat  <= BEAT_W32;
      len   <= '0;
    end else if (load) begin
      valid <= 1'b1;
      addr  <= ld_addr;
      beat  <= ld_beat;
      len   <= ld_len;
    end else if (clear) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xfer_split.sv
module xfer_split
  import xfer_split_pkg::*;
#(
  parameter int BUS_BITS  = 64,
  parameter int ADDR_W    = 32,
  parameter int MAX_WORDS = 16,
  localparam int CNT_W    = $clog2(MAX_WORDS + 1),
  localparam bit WIDE     = (BUS_BITS == 64)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_words,
  input  logic              req_single,
  output logic              req_ready,
  output logic              bus_valid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_wide,
  output logic [CNT_W-1:0]  bus_len,
  input  logic              bus_ready,
  output logic              done
);
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  rem_q;
  logic              single_q;
  logic              start, accept, last, load;
  logic [ADDR_W-1:0] p_addr;
  logic [CNT_W-1:0]  p_rem, p_beats, p_used;
  logic              p_single;
  beat_e             p_beat, st_beat;

  assign req_ready = !bus_valid;
  assign start     = req_valid && !bus_valid;
  assign accept    = bus_valid && bus_ready;
  assign last      = accept && (rem_q == '0);
  assign load      = start || (accept && rem_q != '0);

  assign p_addr   = start ? req_addr   : cur_addr;
  assign p_rem    = start ? req_words  : rem_q;
  assign p_single = start ? req_single : single_q;

  xfer_plan #(.CNT_W(CNT_W)) u_plan (
    .wide_ok   (WIDE && !p_single),
    .odd_word  (p_addr[2]),
    .rem_words (p_rem),
    .beat      (p_beat),
    .beats     (p_beats),
    .used      (p_used)
  );

  xfer_stage #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_stage (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .clear   (last),
    .ld_addr (p_addr),
    .ld_beat (p_beat),
    .ld_len  (p_beats),
    .valid   (bus_valid),
    .addr    (bus_addr),
    .beat    (st_beat),
    .len     (bus_len)
  );

  assign bus_wide = (st_beat == BEAT_W64);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      rem_q    <= '0;
      single_q <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= last;
      if (load) begin
        cur_addr <= p_addr + (ADDR_W'(p_used) << 2);
        rem_q    <= p_rem - p_used;
      end
      if (start) single_q <= req_single;
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_wide) && $stable(bus_len));

  // R5
  single_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid && single_q |-> !bus_wide && bus_len == CNT_W'(1));

  // R3
  wide_align_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_wide |-> !bus_addr[2] && bus_len != '0);

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(bus_valid && bus_ready) && !bus_valid);

  generate
    if (!WIDE) begin : g_narrow
      // R2
      narrow_bus_chk: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> !bus_wide && bus_len == CNT_W'(1));
    end
  endgenerate
endmodule

// File: tb/xfer_split_bench.sv
module xfer_split_bench;
  localparam int AW = 32;
  localparam int CW = 5;

  logic clk = 0;
  logic rst = 1;
  always #4 clk = ~clk;

  logic          req_valid = 0;
  logic [AW-1:0] req_addr = 0;
  logic [CW-1:0] req_words = 0;
  logic          req_single = 0;
  logic          rdy = 1;
  logic [1:0]    rr, bv, bw, dn;
  logic [1:0][AW-1:0] ba;
  logic [1:0][CW-1:0] bl;

  xfer_split #(.BUS_BITS(64)) u_xfer_split (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_words(req_words), .req_single(req_single), .req_ready(rr[0]),
    .bus_valid(bv[0]), .bus_addr(ba[0]), .bus_wide(bw[0]), .bus_len(bl[0]),
    .bus_ready(rdy), .done(dn[0]));

  xfer_split #(.BUS_BITS(32)) u_xfer_split_n (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_words(req_words), .req_single(req_single), .req_ready(rr[1]),
    .bus_valid(bv[1]), .bus_addr(ba[1]), .bus_wide(bw[1]), .bus_len(bl[1]),
    .bus_ready(rdy), .done(dn[1]));

  int checks = 0, fails = 0, cyc = 0;
  int ready_mode = 0;

  // captured transactions per instance
  logic [AW-1:0] c_addr [2][32];
  logic          c_wide [2][32];
  int            c_len  [2][32];
  int            c_n [2], done_cnt [2], done_cyc [2], last_acc [2], stall_err [2];
  logic [1:0]    pv;
  logic          prdy;
  logic [1:0][AW-1:0] pa;
  logic [1:0]    pw;
  logic [1:0][CW-1:0] pl;

  // expected list
  logic [AW-1:0] e_addr [32];
  logic          e_wide [32];
  int            e_len  [32];
  int            e_n;

  initial begin
    pv = 0; prdy = 1; pa = '0; pw = '0; pl = '0;
    for (int i = 0; i < 2; i++) begin
      c_n[i] = 0; done_cnt[i] = 0; done_cyc[i] = -10; last_acc[i] = -20; stall_err[i] = 0;
    end
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst) begin
      for (int i = 0; i < 2; i++) begin
        if (pv[i] && !prdy && (!bv[i] || ba[i] != pa[i] || bw[i] != pw[i] || bl[i] != pl[i]))
          stall_err[i] = stall_err[i] + 1;
        if (bv[i] && rdy) begin
          if (c_n[i] < 32) begin
            c_addr[i][c_n[i]] = ba[i];
            c_wide[i][c_n[i]] = bw[i];
            c_len[i][c_n[i]]  = int'(bl[i]);
          end
          c_n[i] = c_n[i] + 1;
          last_acc[i] = cyc;
        end
        if (dn[i]) begin
          done_cnt[i] = done_cnt[i] + 1;
          done_cyc[i] = cyc;
          if (bv[i]) stall_err[i] = stall_err[i] + 1;
        end
      end
      pv = bv; prdy = rdy; pa = ba; pw = bw; pl = bl;
    end
  end

  // bus_ready pattern source
  initial begin
    int ph;
    ph = 0;
    forever begin
      @(posedge clk); #1;
      ph = (ph + 1) % 3;
      case (ready_mode)
        0: rdy = 1'b1;
        1: rdy = (ph != 0);
        default: rdy = (ph == 0);
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // expected series from the requirement rules
  task automatic build_exp(input bit wide_bus, input logic [AW-1:0] addr,
                           input int n, input bit single);
    logic [AW-1:0] a;
    int r, k;
    a = addr; r = n; e_n = 0;
    while (r > 0) begin
      if (wide_bus && !single && !a[2] && r >= 2) begin
        k = r / 2;
        e_addr[e_n] = a; e_wide[e_n] = 1; e_len[e_n] = k;
        a = a + AW'(8 * k); r = r - 2 * k;
      end else begin
        e_addr[e_n] = a; e_wide[e_n] = 0; e_len[e_n] = 1;
        a = a + 4; r = r - 1;
      end
      e_n++;
    end
  endtask

  task automatic compare(input int i, input string tag);
    chk(c_n[i] == e_n, tag, "transaction count", c_n[i], e_n);
    for (int t = 0; t < e_n && t < c_n[i]; t++) begin
      chk(c_addr[i][t] == e_addr[t], tag, $sformatf("addr of txn %0d", t), c_addr[i][t], e_addr[t]);
      chk(c_wide[i][t] == e_wide[t], tag, $sformatf("width of txn %0d", t), c_wide[i][t], e_wide[t]);
      chk(c_len[i][t] == e_len[t], tag, $sformatf("beats of txn %0d", t), c_len[i][t], e_len[t]);
    end
    // R8 done pulse timing
    chk(done_cnt[i] == 1, "R8", "done pulse count", done_cnt[i], 1);
    chk(done_cyc[i] == last_acc[i] + 1, "R8", "done cycle after last accept", done_cyc[i], last_acc[i] + 1);
  endtask

  task automatic run_case(input string tag, input logic [AW-1:0] addr, input int n,
                          input bit single, input bit poke);
    for (int k = 0; k < 200 && rr != 2'b11; k++) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      c_n[i] = 0; done_cnt[i] = 0; stall_err[i] = 0;
    end
    @(posedge clk); #1;
    req_valid = 1; req_addr = addr; req_words = CW'(n); req_single = single;
    @(posedge clk); #1;
    if (poke) begin
      // R9 request raised while busy
      req_addr = addr + 32'h100; req_words = CW'(3); req_single = 0;
      @(negedge clk);
      chk(rr == 2'b00, "R9", "req_ready while busy", rr, 0);
      @(posedge clk); #1;
      @(posedge clk); #1;
    end
    req_valid = 0;
    for (int k = 0; k < 400 && !(done_cnt[0] >= 1 && done_cnt[1] >= 1); k++) @(negedge clk);
    repeat (4) @(negedge clk);
    build_exp(1'b1, addr, n, single);
    compare(0, tag);
    build_exp(1'b0, addr, n, single);
    compare(1, single ? tag : "R2");
    if (ready_mode != 0) begin
      chk(stall_err[0] == 0, "R7", "hold under stall, 64-bit", stall_err[0], 0);
      chk(stall_err[1] == 0, "R7", "hold under stall, 32-bit", stall_err[1], 0);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(bv == 2'b00, "R1", "bus_valid after reset", bv, 0);
    chk(dn == 2'b00, "R1", "done after reset", dn, 0);
    chk(rr == 2'b11, "R1", "req_ready after reset", rr, 3);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    test_reset();
    run_case("R3", 32'h1000, 4, 0, 0);   // aligned four words
    run_case("R4", 32'h1004, 4, 0, 0);   // odd start: 32/64/32
    run_case("R3", 32'h2000, 5, 0, 0);   // trailing word
    run_case("R3", 32'h3000, 16, 0, 0);  // longest burst
    run_case("R4", 32'h4004, 16, 0, 0);  // odd start, full length
    run_case("R4", 32'h4104, 2, 0, 0);   // odd start, two words
    run_case("R5", 32'h5000, 4, 1, 0);   // single-access region
    run_case("R5", 32'h5004, 7, 1, 0);
    run_case("R6", 32'h6000, 1, 0, 0);
    run_case("R6", 32'h6004, 1, 0, 0);
    ready_mode = 1;
    run_case("R7", 32'h7004, 6, 0, 0);
    ready_mode = 2;
    run_case("R7", 32'h7100, 9, 0, 0);
    run_case("R9", 32'h8004, 8, 0, 1);
    ready_mode = 0;
    run_case("R3", 32'h9008, 2, 0, 0);
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule